// File: doc/BRIEF.md
# I2C Conversion-Result Slave Responder

This block is the slave side of an I2C link for a data converter. It runs on a local system clock and oversamples the SCL and SDA lines through a short synchronizer. From the synchronized lines it detects START, STOP and the rising and falling edges of SCL. It pulls SDA low only through an open-drain enable. The block answers one 7-bit address whose lowest bit comes from a strap input. On a read it returns a two-byte frame made from a 12-bit conversion sample and a 2-bit channel tag.

The block also recognises the high-speed master code. It stays silent on that code and raises a mode flag that lasts until the next STOP. When the master addresses it for a read, the block pulses a one-cycle marker at the ninth rising SCL edge. Logic outside the block uses that marker to time the window in which the master holds SCL high while a conversion starts. Writes are acknowledged at the address level, and any data that follows them is ignored.

Top module: `conv_i2c_slave`

## Requirements
- R1: After reset, sda_oe, hs_mode and conv_start are all low.
- R2: After a START or a repeated START, an address byte whose upper seven bits equal 0,1,0,1,0,0,dev_a0 (sent MSB first, with the R/W bit last) is acknowledged: SDA is held low during the ninth SCL high phase. Any other address byte gets no acknowledge.
- R3: An address-phase byte of the form 0,0,0,0,1,x,x,x is never acknowledged, and it sets hs_mode.
- R4: Once set, hs_mode stays high through repeated STARTs and further transfers, and it clears on the first STOP.
- R5: On an acknowledged read, the first byte sent is 0,0,chan[1],chan[0],sample[11:8], MSB first.
- R6: The second byte, sample[7:0] MSB first, is sent only if the master acknowledged the first byte. After a master NACK the slave leaves SDA released (the master reads all ones).
- R7: After a master NACK on the second byte, sda_oe is low before the master issues STOP.
- R8: conv_start is a single-cycle pulse that follows the ninth rising SCL edge of an acknowledged read address. There is no pulse for a write address or for an address that is not matched.
- R9: sample_i and chan_i are captured when the address matches. Changes to them during the read do not alter the bytes sent.
- R10: The slave changes its SDA drive only while SCL is low, so each data bit is stable across the whole SCL high phase.
- R11: A START or a STOP in the middle of a byte discards the partial byte. A complete address that follows a repeated START is still recognised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line as seen on the bus |
| sda_i | input | 1 | SDA line as seen on the bus (wired-AND value) |
| dev_a0 | input | 1 | Strap for the lowest address bit |
| sample_i | input | 12 | Conversion result to report |
| chan_i | input | 2 | Channel tag to report |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| hs_mode | output | 1 | High-speed mode flag |
| conv_start | output | 1 | One-cycle marker at the ninth rising edge of an acknowledged read address |

## Verification
On every cycle the assertions check four things. The SDA drive only turns on while SCL is low. hs_mode only rises after an SCL rising edge and is low right after any STOP. conv_start lasts exactly one cycle and always falls inside the slave's own acknowledge. The bench scenarios cover everything that depends on a whole transaction: the exact bit order of both data bytes over a sweep of samples, channels and strap values, silence on the master code, recovery from truncated bytes, the early release after NACKs, and the capture of the sample at address match.

// File: rtl/cvr_pkg.sv
package cvr_pkg;
    localparam int BYTE_W = 8;
    localparam logic [5:0] ADDR_UPPER = 6'b010100;
    localparam logic [4:0] HS_PREFIX  = 5'b00001;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK_SET,
        ST_AACK_HOLD,
        ST_AACK_END,
        ST_TX,
        ST_TX_REL,
        ST_MACK,
        ST_MACK_END,
        ST_DONE
    } slv_state_e;
endpackage

// File: rtl/cvr_line_mon.sv
module cvr_line_mon #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    logic [STAGES-1:0] scl_sync_d, scl_sync_q;
    logic [STAGES-1:0] sda_sync_d, sda_sync_q;
    logic              scl_prev_d, scl_prev_q;
    logic              sda_prev_d, sda_prev_q;

    always_comb begin
        scl_sync_d = {scl_sync_q[STAGES-2:0], scl_i};
        sda_sync_d = {sda_sync_q[STAGES-2:0], sda_i};
        scl_prev_d = scl_sync_q[STAGES-1];
        sda_prev_d = sda_sync_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync_q <= '1;
            sda_sync_q <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_sync_q <= scl_sync_d;
            sda_sync_q <= sda_sync_d;
            scl_prev_q <= scl_prev_d;
            sda_prev_q <= sda_prev_d;
        end
    end

    assign scl_s    = scl_sync_q[STAGES-1];
    assign sda_s    = sda_sync_q[STAGES-1];
    assign scl_rise = scl_s & ~scl_prev_q;
    assign scl_fall = ~scl_s & scl_prev_q;
    assign start_p  = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    assign stop_p   = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
endmodule

// File: rtl/cvr_frame_pack.sv
module cvr_frame_pack #(
    parameter int RES_W = 12,
    parameter int CH_W  = 2
) (
    input  logic [RES_W-1:0] sample,
    input  logic [CH_W-1:0]  chan,
    output logic [7:0]       byte_hi,
    output logic [7:0]       byte_lo
);
    localparam int HI_BITS = RES_W - 8;
    localparam int PAD_W   = 8 - CH_W - HI_BITS;

    generate
        if (PAD_W > 0) begin : g_pad
            assign byte_hi = {{PAD_W{1'b0}}, chan, sample[RES_W-1:8]};
        end else begin : g_nopad
            assign byte_hi = {chan, sample[RES_W-1:8]};
        end
    endgenerate

    assign byte_lo = sample[7:0];
endmodule

// File: rtl/conv_i2c_slave.sv
module conv_i2c_slave
    import cvr_pkg::*;
#(
    parameter int RES_W       = 12,
    parameter int CH_W        = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             dev_a0,
    input  logic [RES_W-1:0] sample_i,
    input  logic [CH_W-1:0]  chan_i,
    output logic             sda_oe,
    output logic             hs_mode,
    output logic             conv_start
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        slv_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       sh;
        logic             oe;
        logic             hs;
        logic             conv;
        logic             rw;
        logic             idx;
        logic [7:0]       hi;
        logic [7:0]       lo;
    } slv_regs_t;

    slv_regs_t r_d, r_q;

    logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
    logic [7:0] frame_hi, frame_lo;
    logic [7:0] rx_byte;

    cvr_line_mon #(.STAGES(SYNC_STAGES)) u_mon (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_p(start_p), .stop_p(stop_p)
    );

    cvr_frame_pack #(.RES_W(RES_W), .CH_W(CH_W)) u_pack (
        .sample(sample_i), .chan(chan_i), .byte_hi(frame_hi), .byte_lo(frame_lo)
    );

    assign rx_byte = {r_q.sh[6:0], sda_s};

    always_comb begin
        r_d      = r_q;
        r_d.conv = 1'b0;
        if (stop_p) begin
            r_d.state = ST_IDLE;
            r_d.oe    = 1'b0;
            r_d.hs    = 1'b0;
            r_d.cnt   = '0;
        end else if (start_p) begin
            r_d.state = ST_ADDR;
            r_d.oe    = 1'b0;
            r_d.cnt   = '0;
        end else begin
            unique case (r_q.state)
                ST_ADDR: if (scl_rise) begin
                    r_d.sh  = rx_byte;
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == LAST_BIT) begin
                        if (rx_byte[7:1] == {ADDR_UPPER, dev_a0}) begin
                            r_d.state = ST_AACK_SET;
                            r_d.rw    = rx_byte[0];
                            r_d.hi    = frame_hi;
                            r_d.lo    = frame_lo;
                        end else begin
                            if (rx_byte[7:3] == HS_PREFIX) r_d.hs = 1'b1;
                            r_d.state = ST_DONE;
                        end
                    end
                end
                ST_AACK_SET: if (scl_fall) begin
                    r_d.oe    = 1'b1;
                    r_d.state = ST_AACK_HOLD;
                end
                ST_AACK_HOLD: if (scl_rise) begin
                    r_d.conv  = r_q.rw;
                    r_d.state = ST_AACK_END;
                end
                ST_AACK_END: if (scl_fall) begin
                    if (r_q.rw) begin
                        r_d.sh    = r_q.hi;
                        r_d.oe    = ~r_q.hi[7];
                        r_d.cnt   = '0;
                        r_d.idx   = 1'b0;
                        r_d.state = ST_TX;
                    end else begin
                        r_d.oe    = 1'b0;
                        r_d.state = ST_DONE;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                        if (r_q.cnt == LAST_BIT) r_d.state = ST_TX_REL;
                    end else if (scl_fall) begin
                        r_d.sh = {r_q.sh[6:0], 1'b1};
                        r_d.oe = ~r_q.sh[6];
                    end
                end
                ST_TX_REL: if (scl_fall) begin
                    r_d.oe    = 1'b0;
                    r_d.state = ST_MACK;
                end
                ST_MACK: if (scl_rise) begin
                    if (!sda_s && !r_q.idx) r_d.state = ST_MACK_END;
                    else                    r_d.state = ST_DONE;
                end
                ST_MACK_END: if (scl_fall) begin
                    r_d.sh    = r_q.lo;
                    r_d.oe    = ~r_q.lo[7];
                    r_d.cnt   = '0;
                    r_d.idx   = 1'b1;
                    r_d.state = ST_TX;
                end
                default: r_d.oe = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, cnt: '0, sh: '0, oe: 1'b0, hs: 1'b0,
                     conv: 1'b0, rw: 1'b0, idx: 1'b0, hi: '0, lo: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe     = r_q.oe;
    assign hs_mode    = r_q.hs;
    assign conv_start = r_q.conv;
endmodule

module cvr_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic scl_rise,
    input logic stop_p,
    input logic sda_oe,
    input logic hs_mode,
    input logic conv_start
);
    // R10
    oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);
    // R3
    hs_set_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_mode) |-> $past(scl_rise));
    // R4
    hs_stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_p) |-> !hs_mode);
    // R8
    conv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    // R8
    conv_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> sda_oe);
endmodule

bind conv_i2c_slave cvr_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_rise(scl_rise),
    .stop_p(stop_p), .sda_oe(sda_oe), .hs_mode(hs_mode), .conv_start(conv_start)
);

// File: tb/conv_i2c_slave_bench.sv
module conv_i2c_slave_bench;
    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        dev_a0 = 1'b0;
    logic [11:0] sample_i = '0;
    logic [1:0]  chan_i = '0;
    logic        sda_oe, hs_mode, conv_start;
    logic        bus_sda;

    int tests = 0;
    int fails = 0;
    int conv_cnt = 0;

    assign bus_sda = m_sda & ~sda_oe;

    always #4 clk = ~clk;

    conv_i2c_slave u_conv_i2c_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda),
        .dev_a0(dev_a0), .sample_i(sample_i), .chan_i(chan_i),
        .sda_oe(sda_oe), .hs_mode(hs_mode), .conv_start(conv_start)
    );

    always @(posedge clk) if (conv_start) conv_cnt <= conv_cnt + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_rstart();
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(2 * Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            wq(2); m_sda = b[i]; wq(Q); m_scl = 1'b1; wq(Q); m_scl = 1'b0;
        end
    endtask

    task automatic write_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        wq(2); m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q / 2);
        ack = !bus_sda;
        wq(Q / 2); m_scl = 1'b0;
    endtask

    task automatic read_byte(input bit give_ack, output logic [7:0] d, output bit stable);
        stable = 1'b1;
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q); m_scl = 1'b1; wq(2);
            d[i] = bus_sda;
            wq(Q - 4);
            if (bus_sda !== d[i]) stable = 1'b0;
            wq(2); m_scl = 1'b0;
        end
        wq(2); m_sda = give_ack ? 1'b0 : 1'b1;
        wq(Q); m_scl = 1'b1; wq(Q); m_scl = 1'b0; wq(2); m_sda = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        bit ack, st;
        logic [7:0] d;
        int c0;
        logic [11:0] s;
        wq(5);
        // R1 reset state
        check(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
        check(hs_mode == 1'b0, "R1 hs_mode", hs_mode, 0);
        check(conv_start == 1'b0, "R1 conv_start", conv_start, 0);
        rst_n = 1'b1;
        wq(5);

        // R2 wrong strap bit: no acknowledge, R8 no pulse
        dev_a0 = 1'b0; c0 = conv_cnt;
        bus_start(); write_byte(8'b0101_0011, ack); bus_stop();
        check(!ack, "R2 mismatch nack", ack, 0);
        check(conv_cnt == c0, "R8 no pulse on mismatch", conv_cnt, c0);

        // R2 write address acknowledged, R8 no pulse on write
        bus_start(); write_byte(8'b0101_0000, ack); bus_stop();
        check(ack, "R2 write addr ack", ack, 1);
        check(conv_cnt == c0, "R8 no pulse on write", conv_cnt, c0);

        // R3 master code silence, R4 persistence and clearing
        sample_i = 12'hA5C; chan_i = 2'd2;
        bus_start(); write_byte(8'b0000_1101, ack);
        check(!ack, "R3 master code nack", ack, 0);
        check(hs_mode == 1'b1, "R3 hs set", hs_mode, 1);
        bus_rstart(); write_byte(8'b0101_0001, ack);
        check(ack, "R4 addr ack after Sr", ack, 1);
        check(hs_mode == 1'b1, "R4 hs held through Sr", hs_mode, 1);
        read_byte(1'b1, d, st);
        check(d == 8'h2A, "R5 byte1 in hs", d, 8'h2A);
        read_byte(1'b0, d, st);
        check(d == 8'h5C, "R6 byte2 in hs", d, 8'h5C);
        check(hs_mode == 1'b1, "R4 hs held before stop", hs_mode, 1);
        bus_stop();
        check(hs_mode == 1'b0, "R4 hs cleared by stop", hs_mode, 0);

        // Sweep: strap, channel, sample patterns (R2 R5 R6 R7 R8 R10)
        for (int a = 0; a < 2; a++) begin
            for (int ch = 0; ch < 4; ch++) begin
                for (int k = 0; k < 8; k++) begin
                    s = 12'((k * 723 + ch * 273 + a * 7) % 4096);
                    dev_a0 = a[0]; chan_i = ch[1:0]; sample_i = s;
                    c0 = conv_cnt;
                    bus_start(); write_byte({6'b010100, a[0], 1'b1}, ack);
                    check(ack, "R2 sweep addr ack", ack, 1);
                    check(conv_cnt == c0 + 1, "R8 one pulse per read", conv_cnt, c0 + 1);
                    read_byte(1'b1, d, st);
                    check(int'(d) == ch * 16 + int'(s) / 256, "R5 byte1", d, ch * 16 + int'(s) / 256);
                    check(st, "R10 byte1 stable while SCL high", st, 1);
                    read_byte(1'b0, d, st);
                    check(int'(d) == int'(s) % 256, "R6 byte2", d, int'(s) % 256);
                    check(st, "R10 byte2 stable while SCL high", st, 1);
                    check(sda_oe == 1'b0, "R7 released before stop", sda_oe, 0);
                    bus_stop();
                end
            end
        end

        // R6 master NACK after first byte: no second byte
        dev_a0 = 1'b1; chan_i = 2'd1; sample_i = 12'h000;
        bus_start(); write_byte(8'b0101_0011, ack);
        read_byte(1'b0, d, st);
        check(d == 8'h10, "R6 byte1 before nack", d, 8'h10);
        read_byte(1'b0, d, st);
        check(d == 8'hFF, "R6 no byte2 after nack", d, 8'hFF);
        bus_stop();

        // R9 capture at address match
        chan_i = 2'd3; sample_i = 12'h123;
        bus_start(); write_byte(8'b0101_0011, ack);
        chan_i = 2'd0; sample_i = 12'hFFF;
        read_byte(1'b1, d, st);
        check(d == 8'h31, "R9 byte1 held", d, 8'h31);
        read_byte(1'b0, d, st);
        check(d == 8'h23, "R9 byte2 held", d, 8'h23);
        bus_stop();

        // R11 START in mid byte discards partial bits
        bus_start(); send_bits(8'b0101_0011, 3);
        bus_rstart(); write_byte(8'b0101_0011, ack);
        check(ack, "R11 addr after mid-byte Sr", ack, 1);
        read_byte(1'b0, d, st);
        check(d == 8'h0F, "R11 byte1 after restart", d, 8'h0F);
        bus_stop();

        // R11 STOP in mid byte discards partial bits
        bus_start(); send_bits(8'b0101_0011, 4);
        wq(2); m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(2 * Q);
        check(sda_oe == 1'b0, "R11 idle after mid-byte stop", sda_oe, 0);
        bus_start(); write_byte(8'b0101_0011, ack);
        check(ack, "R11 addr after mid-byte stop", ack, 1);
        read_byte(1'b0, d, st);
        bus_stop();

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule